// File: doc/BRIEF.md
# Configuration Register CRC Monitor

This block guards a bank of configuration registers against silent corruption. The register file presents all protected registers as one flat 256-bit image. Some positions in that image belong to reserved fields, and those fields always carry fixed constants. The monitor feeds the image, one bit per clock and lowest bit first, through a serial CRC-32 generator. It then places the 32-bit result in a read-only checksum output.

A new computation starts after a synchronous reset and on every configuration write, which the register file signals with a one-cycle strobe. A write that arrives while a computation is running aborts that computation and begins again from the seed, using the updated image. The previous checksum stays visible until a fresh result replaces it. Software or a supervisor reads the checksum from time to time. If two readings differ, the configuration has changed.

Top module: `crc_mon`

## Requirements
- R1: While reset is high and after it falls, `busy` is 1 and `checksum` reads 0 until the first computation completes.
- R2: A computation occupies exactly 256 rising edges, counted from the edge that starts it (reset or `cfgWrite`). `busy` falls and `checksum` updates on the 256th edge.
- R3: Image bit 0 enters first and bit 255 enters last. The state starts at all ones. The generator is 0x04C11DB7, where bit i is the coefficient of x^i. Each step computes fb = bit XOR state[31] and then state = (state << 1) XOR (fb ? 0x04C11DB7 : 0). The final state is the checksum, with no reflection and no inversion.
- R4: While a computation runs, `checksum` keeps its previous value.
- R5: A `cfgWrite` during a computation restarts it from the seed using the image present at that edge. The next result depends only on that image and arrives 256 edges after the strobe.
- R6: A `cfgWrite` on the same edge as the final step takes priority. No result is latched, `checksum` keeps its old value, and `busy` stays 1.
- R7: Image bits 111:0 are reserved. The input value on these bits is ignored and replaced by the constant 0x5A3C repeated seven times. Bits 255:112 are used as presented.
- R8: While idle, a change of `image` without `cfgWrite` starts nothing. `busy` stays 0 and `checksum` is unchanged.
- R9: A `cfgWrite` while idle raises `busy` on the next edge and begins a new computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; starts a computation |
| image | input | 256 | Concatenated protected register image, bit 0 enters first |
| cfgWrite | input | 1 | One-cycle strobe, high when a protected register is written |
| checksum | output | 32 | Last completed CRC-32 of the image |
| busy | output | 1 | High while a computation is in progress |

## Verification
A configuration write and the final step of a computation can land on the same rising edge. At that edge the block must decide whether to latch a result or restart. The bench lets a computation run to its last step, then raises `cfgWrite` with a new image during exactly that cycle. It judges that `busy` stays high, that the checksum keeps its earlier value, and that the next result matches the new image 256 edges later. A write in the middle of a run is also provoked to show that the aborted partial result never appears.

// File: rtl/crc_mon_pkg.sv
package crc_mon_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic seed;   // load the seed into the running state
    logic step;   // absorb one image bit
    logic latch;  // copy the next state into the checksum register
  } crcStrobe_t;

  localparam int unsigned DEF_IMG_W = 256;
  localparam int unsigned DEF_CRC_W = 32;

endpackage

// File: rtl/crc_mon_ctrl.sv
module crc_mon_ctrl
  import crc_mon_pkg::*;
#(
  parameter int unsigned IMG_W = DEF_IMG_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfgWrite,
  output crcStrobe_t               strobe,
  output logic [$clog2(IMG_W)-1:0] bitIdx,
  output logic                     busy
);

  localparam int unsigned IDX_W = $clog2(IMG_W);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(IMG_W - 1);

  logic [CNT_W-1:0] stepCnt;
  logic             running;
  logic             restart;

  assign restart = rst | cfgWrite;

  // A restart has priority over every other action, including the final step
  always_ff @(posedge clk) begin
    if (restart) begin
      stepCnt <= '0;
      running <= 1'b1;
    end else if (running) begin
      stepCnt <= stepCnt + 1'b1;
      if (stepCnt == LAST_STEP) begin
        running <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (restart) begin
      strobe.seed = 1'b1;
    end else if (running) begin
      strobe.step  = 1'b1;
      strobe.latch = (stepCnt == LAST_STEP);
    end
  end

  assign bitIdx = stepCnt[IDX_W-1:0];
  assign busy   = running;

endmodule

// File: rtl/crc_mon_datapath.sv
module crc_mon_datapath
  import crc_mon_pkg::*;
#(
  parameter int unsigned      IMG_W      = DEF_IMG_W,
  parameter int unsigned      CRC_W      = DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY       = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] SEED       = '1,
  parameter logic [IMG_W-1:0] RSVD_MASK  = '0,
  parameter logic [IMG_W-1:0] RSVD_VALUE = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  crcStrobe_t               strobe,
  input  logic [$clog2(IMG_W)-1:0] bitIdx,
  input  logic [IMG_W-1:0]         image,
  output logic [CRC_W-1:0]         checksum
);

  logic [IMG_W-1:0] effImage;
  logic             curBit;
  logic             feedBack;
  logic [CRC_W-1:0] crcState;
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] sumReg;

  // Reserved positions always carry their constants, whatever the input holds
  assign effImage = (image & ~RSVD_MASK) | (RSVD_VALUE & RSVD_MASK);
  assign curBit   = effImage[bitIdx];
  assign feedBack = curBit ^ crcState[CRC_W-1];

  // One shift of the Galois-form generator
  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == 0) begin : g_low
      assign crcNext[i] = feedBack & POLY[i];
    end else begin : g_up
      assign crcNext[i] = crcState[i-1] ^ (feedBack & POLY[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.seed) begin
      crcState <= SEED;
    end else if (strobe.step) begin
      crcState <= crcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg <= '0;
    end else if (strobe.latch) begin
      sumReg <= crcNext;
    end
  end

  assign checksum = sumReg;

endmodule

// File: rtl/crc_mon.sv
module crc_mon
  import crc_mon_pkg::*;
#(
  parameter int unsigned      IMG_W      = DEF_IMG_W,
  parameter int unsigned      CRC_W      = DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY       = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] SEED       = '1,
  parameter logic [IMG_W-1:0] RSVD_MASK  = {{(IMG_W-112){1'b0}}, {112{1'b1}}},
  parameter logic [IMG_W-1:0] RSVD_VALUE = {{(IMG_W-112){1'b0}}, {7{16'h5A3C}}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IMG_W-1:0] image,
  input  logic             cfgWrite,
  output logic [CRC_W-1:0] checksum,
  output logic             busy
);

  localparam int unsigned IDX_W = $clog2(IMG_W);

  crcStrobe_t       strobe;
  logic [IDX_W-1:0] bitIdx;

  crc_mon_ctrl #(
    .IMG_W(IMG_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfgWrite(cfgWrite),
    .strobe  (strobe),
    .bitIdx  (bitIdx),
    .busy    (busy)
  );

  crc_mon_datapath #(
    .IMG_W     (IMG_W),
    .CRC_W     (CRC_W),
    .POLY      (POLY),
    .SEED      (SEED),
    .RSVD_MASK (RSVD_MASK),
    .RSVD_VALUE(RSVD_VALUE)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .bitIdx  (bitIdx),
    .image   (image),
    .checksum(checksum)
  );

endmodule

// File: rtl/crc_mon_checker.sv
module crc_mon_checker #(
  parameter int unsigned IMG_W = 256,
  parameter int unsigned CRC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfgWrite,
  input logic [CRC_W-1:0] checksum,
  input logic             busy
);

  localparam int unsigned CNT_W = $clog2(IMG_W) + 2;

  // Edges since the last start, counted independently of the design
  logic [CNT_W-1:0] runLen;
  logic             doneOnce;

  always_ff @(posedge clk) begin
    if (rst || cfgWrite) begin
      runLen <= '0;
    end else if (busy) begin
      runLen <= runLen + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doneOnce <= 1'b0;
    end else if (busy && !cfgWrite && runLen == CNT_W'(IMG_W - 1)) begin
      doneOnce <= 1'b1;
    end
  end

  // R1: zero until the first result
  p_zero_first_r1: assert property (@(posedge clk) disable iff (rst)
    !doneOnce |-> checksum == '0);

  // R2: a run ends after exactly IMG_W edges
  p_run_length_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> runLen == CNT_W'(IMG_W));

  // R4: the checksum moves only when a run ends
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(checksum) |-> $fell(busy));

  // R6: a write during a run keeps it running and keeps the old result
  p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && cfgWrite) |=> (busy && $stable(checksum)));

  // R8: idle without a write stays idle
  p_idle_stays_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cfgWrite) |=> !busy);

  // R9: a write always starts a run
  p_write_starts_r9: assert property (@(posedge clk) disable iff (rst)
    cfgWrite |=> busy);

endmodule

bind crc_mon crc_mon_checker #(
  .IMG_W(IMG_W),
  .CRC_W(CRC_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfgWrite(cfgWrite),
  .checksum(checksum),
  .busy    (busy)
);

// File: tb/crc_mon_test.sv
module crc_mon_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [255:0] MASK_R7 = {144'h0, {112{1'b1}}};
  localparam logic [255:0] CONST_R7 = {144'h0, {7{16'h5A3C}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [255:0] image = '0;
  logic         cfgWrite = 1'b0;
  logic [31:0]  checksum;
  logic         busy;

  int checkCount = 0;
  int failCount = 0;

  crc_mon uut (
    .clk     (clk),
    .rst     (rst),
    .image   (image),
    .cfgWrite(cfgWrite),
    .checksum(checksum),
    .busy    (busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reference computed from R3 and R7
  function automatic logic [31:0] refCrc(input logic [255:0] img);
    logic [255:0] eff;
    logic [31:0]  s;
    eff = (img & ~MASK_R7) | (CONST_R7 & MASK_R7);
    s = 32'hFFFF_FFFF;
    for (int k = 0; k < 256; k++) begin
      logic fb;
      fb = eff[k] ^ s[31];
      s = {s[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
    end
    return s;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Present an image with a write strobe; returns at the negedge after the restart edge
  task automatic doWrite(input logic [255:0] img);
    @(negedge clk);
    image = img;
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic testReset(input logic [255:0] img);
    @(negedge clk);
    image = img;
    rst = 1'b1;
    waitNeg(3);
    check1("R1 busy in reset", busy, 1'b1);
    check32("R1 checksum in reset", checksum, 32'h0);
    rst = 1'b0;
    waitNeg(255);
    check1("R2 busy before last step", busy, 1'b1);
    check32("R1 checksum before first result", checksum, 32'h0);
    waitNeg(1);
    check1("R2 busy after 256 edges", busy, 1'b0);
    check32("R3 checksum after reset", checksum, refCrc(img));
  endtask

  task automatic testHold(input logic [255:0] img);
    logic [31:0] old;
    old = checksum;
    doWrite(img);
    check1("R9 busy after idle write", busy, 1'b1);
    waitNeg(128);
    check32("R4 checksum held mid-run", checksum, old);
    waitNeg(127);
    check32("R4 checksum held at last step", checksum, old);
    waitNeg(1);
    check1("R2 busy after write run", busy, 1'b0);
    check32("R3 checksum after write", checksum, refCrc(img));
  endtask

  task automatic testRestart(input logic [255:0] a, input logic [255:0] b);
    logic [31:0] old;
    old = checksum;
    doWrite(a);
    waitNeg(100);
    doWrite(b);
    waitNeg(255);
    check1("R5 busy before restarted end", busy, 1'b1);
    check32("R5 old value during restarted run", checksum, old);
    waitNeg(1);
    check1("R5 busy after restarted run", busy, 1'b0);
    check32("R5 result from new image", checksum, refCrc(b));
  endtask

  task automatic testLastCycle(input logic [255:0] a, input logic [255:0] b);
    logic [31:0] old;
    old = checksum;
    doWrite(a);
    waitNeg(255);
    image = b;
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    check1("R6 busy after write on last step", busy, 1'b1);
    check32("R6 checksum not latched", checksum, old);
    waitNeg(255);
    check1("R6 busy before end", busy, 1'b1);
    waitNeg(1);
    check1("R6 busy at end", busy, 1'b0);
    check32("R6 result from late image", checksum, refCrc(b));
  endtask

  task automatic testReserved(input logic [255:0] base);
    logic [255:0] alt;
    alt = base ^ {144'h0, {7{16'hFFFF}}};
    doWrite(base);
    waitNeg(256);
    check32("R7 reserved masked (base)", checksum, refCrc(base));
    doWrite(alt);
    waitNeg(256);
    check32("R7 reserved input ignored", checksum, refCrc(base));
    alt = base ^ (256'h1 << 112);
    doWrite(alt);
    waitNeg(256);
    check32("R7 bit 112 used", checksum, refCrc(alt));
    check1("R7 lowest used bit changes result", checksum != refCrc(base), 1'b1);
  endtask

  task automatic testIdleChange(input logic [255:0] img);
    logic [31:0] old;
    old = checksum;
    @(negedge clk);
    image = img;
    waitNeg(300);
    check1("R8 busy stays low", busy, 1'b0);
    check32("R8 checksum unchanged", checksum, old);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin : main
    logic [255:0] imgA, imgB, imgC;
    imgA = {8{32'hDEAD_BEEF}};
    imgB = {8{32'h0123_4567}} ^ {4{64'hF0F0_0000_FFFF_0101}};
    imgC = '1;
    testReset('0);
    testHold(imgA);
    testRestart(imgB, imgC);
    testLastCycle(imgA, imgB);
    testReserved(imgC ^ {2{128'h8000_0000_0000_0001_0000_0000_0000_00FF}});
    testIdleChange(imgA ^ imgB);
    testReset(imgB);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule